// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator with Bypass

This block gathers up to 64 level-sensitive peripheral interrupt lines and folds them into a small set of parent interrupt outputs. The lines are split into 32-bit words. Each word has an enable register that software can write and a status register that is read-only. A fixed map mask for each parent and each word chooses which source bits may raise that parent. A fixed forward mask picks sources that skip the aggregator. Those sources drive a direct bypass line that the parent controller sees, and they never reach a parent output or the wake output.

Software changes enables only by rewriting a whole enable word. There is no set or clear alias, so a change takes a read-modify-write. Bit positions with no wired source read as zero. Enabling such a bit has no effect. When the wake parameter is set, a registered wake output reports that any enabled, unforwarded source is active.

Top module: `l2irq_top`

## Requirements
- R1: While `rst_ni` is low and after it rises, every enable bit reads 0, and `parent_irq_o` and `wake_o` are 0.
- R2: A write (`req_i`=1, `we_i`=1) to an enable address stores `wdata_i` ANDed with that word's wired mask. A read returns the stored value, so enable bits at unwired positions read 0.
- R3: The status word reads the live level of `src_i` ANDed with the wired mask. A write to a status address leaves every enable word unchanged.
- R4: `addr_i` is the byte offset divided by 4. Value 0 (offset 0x0) is enable word 0 and 1 (0x4) is status word 0. Value 2 (0x8) is enable word 1 and 3 (0xC) is status word 1. Word 0 covers sources 0 to 31 and word 1 covers sources 32 to 63. `rdata_o` shows the addressed register combinationally.
- R5: `parent_irq_o[k]` is a register. One clock edge after the inputs change, it equals the OR over all source bits that are wired, enabled, unforwarded and selected by parent k's map masks.
- R6: `MAP_MASK` is packed parent by parent and then word by word. The mask for parent k and word w sits at bits `[(k*NW+w)*32 +: 32]`.
- R7: `bypass_o[i]` follows `src_i[i]` combinationally when bit i is both forwarded and wired, and is 0 otherwise. Forwarded sources never raise `parent_irq_o` or `wake_o`.
- R8: With `WAKE_EN`=1, `wake_o` is a register that goes high one edge after any wired, enabled, unforwarded source is high, whatever the map masks say. With `WAKE_EN`=0 it stays 0.
- R9: A new enable value changes the parent outputs at the clock edge after the one that stores the write.
- R10: An active source at an unwired position raises no output, even after all ones are written to its enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NW*32 | Level-sensitive source lines |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 2 | Word address (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed register |
| parent_irq_o | output | NP | Parent interrupt outputs, registered |
| bypass_o | output | NW*32 | Direct lines for forwarded sources |
| wake_o | output | 1 | Wake request, registered |

## Verification
The assertions check several properties on every cycle:
- bypass lines stay low outside the forward mask;
- all outputs stay silent one cycle after no unforwarded wired source is high;
- any active parent implies wake;
- unwired status bits read zero;
- a write to a status address never disturbs the enable words.

Some behaviour needs known stimulus and a model, so only the bench scenarios show it:
- the exact parent chosen through the packed map layout;
- the one-cycle latency after a source or enable change;
- the masking of unwired enable bits on read-back;
- the reset values.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;
  localparam int unsigned WordW = 32;
  typedef logic [WordW-1:0] word_t;
endpackage

// File: rtl/l2irq_regs.sv
module l2irq_regs
  import l2irq_pkg::*;
#(
  parameter int unsigned      NW    = 2,
  parameter logic [NW*32-1:0] WIRED = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  word_t            wdata_i,
  input  logic [NW*32-1:0] status_i,
  output logic [NW*32-1:0] en_o,
  output word_t            rdata_o
);
  word_t en_q [NW];

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic wr_en;
    assign wr_en = req_i && we_i && !addr_i[0] && (addr_i[1] == 1'(w));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    en_q[w] <= '0;
      else if (wr_en) en_q[w] <= wdata_i & WIRED[w*WordW +: WordW];
    end
    assign en_o[w*WordW +: WordW] = en_q[w];
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NW; w++) begin
      if (addr_i[1] == 1'(w))
        rdata_o = addr_i[0] ? status_i[w*WordW +: WordW] : en_q[w];
    end
  end
endmodule

// File: rtl/l2irq_route.sv
module l2irq_route
  import l2irq_pkg::*;
#(
  parameter int unsigned         NW       = 2,
  parameter int unsigned         NP       = 2,
  parameter logic [NP*NW*32-1:0] MAP_MASK = '0,
  parameter logic [NW*32-1:0]    FWD_MASK = '0,
  parameter bit                  WAKE_EN  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NW*32-1:0] status_i,
  input  logic [NW*32-1:0] en_i,
  output logic [NP-1:0]    parent_irq_o,
  output logic             wake_o
);
  localparam int unsigned SrcW = NW * WordW;

  logic [SrcW-1:0] live;
  logic [NP-1:0]   hit;

  assign live = status_i & en_i & ~FWD_MASK;

  // parent k owns a contiguous SrcW slice, word 0 in the low bits
  for (genvar k = 0; k < NP; k++) begin : g_par
    assign hit[k] = |(live & MAP_MASK[k*SrcW +: SrcW]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) parent_irq_o <= '0;
    else         parent_irq_o <= hit;
  end

  if (WAKE_EN) begin : g_wake
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wake_o <= 1'b0;
      else         wake_o <= |live;
    end
  end else begin : g_nowake
    assign wake_o = 1'b0;
  end
endmodule

// File: rtl/l2irq_top.sv
module l2irq_top
  import l2irq_pkg::*;
#(
  parameter int unsigned         NW       = 2,
  parameter int unsigned         NP       = 2,
  parameter logic [NW*32-1:0]    WIRED    = '1,
  parameter logic [NP*NW*32-1:0] MAP_MASK = {64'hFFFF_FFFF_0000_0000, 64'h0000_0000_FFFF_FFFF},
  parameter logic [NW*32-1:0]    FWD_MASK = '0,
  parameter bit                  WAKE_EN  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NW*32-1:0] src_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic [NP-1:0]    parent_irq_o,
  output logic [NW*32-1:0] bypass_o,
  output logic             wake_o
);
  logic [NW*32-1:0] status;
  logic [NW*32-1:0] en_q;

  assign status   = src_i & WIRED;
  assign bypass_o = status & FWD_MASK;

  l2irq_regs #(.NW(NW), .WIRED(WIRED)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .status_i (status),
    .en_o     (en_q),
    .rdata_o  (rdata_o)
  );

  l2irq_route #(
    .NW(NW), .NP(NP), .MAP_MASK(MAP_MASK), .FWD_MASK(FWD_MASK), .WAKE_EN(WAKE_EN)
  ) i_route (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .status_i     (status),
    .en_i         (en_q),
    .parent_irq_o (parent_irq_o),
    .wake_o       (wake_o)
  );
endmodule

// File: rtl/l2irq_chk.sv
module l2irq_chk #(
  parameter int unsigned      NW       = 2,
  parameter int unsigned      NP       = 2,
  parameter logic [NW*32-1:0] WIRED    = '1,
  parameter logic [NW*32-1:0] FWD_MASK = '0,
  parameter bit               WAKE_EN  = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NW*32-1:0] src_i,
  input logic             req_i,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [31:0]      rdata_o,
  input logic [NP-1:0]    parent_irq_o,
  input logic [NW*32-1:0] bypass_o,
  input logic             wake_o,
  input logic [NW*32-1:0] en_i
);
  logic [31:0] wired_sel;
  always_comb begin
    wired_sel = '0;
    for (int w = 0; w < NW; w++)
      if (addr_i[1] == 1'(w)) wired_sel = WIRED[w*32 +: 32];
  end

  // R7
  bypass_fwd_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_o & ~FWD_MASK) == '0);

  // R7
  fwd_no_parent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_i & WIRED & ~FWD_MASK) == '0) |=> (parent_irq_o == '0 && !wake_o));

  // R8
  if (WAKE_EN) begin : g_wake
    parent_implies_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (parent_irq_o != '0) |-> wake_o);
  end else begin : g_nowake
    wake_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !wake_o);
  end

  // R3
  status_unwired_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[0]) |-> ((rdata_o & ~wired_sel) == '0));

  // R3
  status_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[0]) |=> $stable(en_i));

  // R2
  en_unwired_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i & ~WIRED) == '0);
endmodule

bind l2irq_top l2irq_chk #(
  .NW(NW), .NP(NP), .WIRED(WIRED), .FWD_MASK(FWD_MASK), .WAKE_EN(WAKE_EN)
) i_l2irq_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .src_i        (src_i),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .rdata_o      (rdata_o),
  .parent_irq_o (parent_irq_o),
  .bypass_o     (bypass_o),
  .wake_o       (wake_o),
  .en_i         (en_q)
);

// File: tb/test_l2irq_top.sv
module test_l2irq_top;
  localparam int unsigned NW = 2;
  localparam int unsigned NP = 3;
  localparam logic [63:0]  WIRED = 64'h0FFF_00FF_FFFF_7FFE;
  localparam logic [63:0]  FWD   = 64'h0000_0002_0000_0006;
  localparam logic [191:0] MAP   = {32'hFFFF_FF00, 32'h0000_0000,
                                    32'h0000_00FF, 32'hFFFF_0000,
                                    32'h0000_0000, 32'h0000_00FF};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] par;
  logic [63:0] byp;
  logic        wake;

  int n_chk = 0, n_fail = 0;
  logic [63:0] en_m = '0;

  always #10 clk = ~clk;

  l2irq_top #(.NW(NW), .NP(NP), .WIRED(WIRED), .MAP_MASK(MAP),
              .FWD_MASK(FWD), .WAKE_EN(1'b1)) i_l2irq_top (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .parent_irq_o(par),
    .bypass_o(byp), .wake_o(wake));

  function automatic logic [63:0] live_f(logic [63:0] s, logic [63:0] e);
    return s & WIRED & ~FWD & e;
  endfunction

  function automatic logic [NP-1:0] exp_par(logic [63:0] s, logic [63:0] e);
    logic [NP-1:0] r = '0;
    for (int k = 0; k < NP; k++)
      for (int w = 0; w < NW; w++)
        if (|(live_f(s, e)[w*32 +: 32] & MAP[(k*NW+w)*32 +: 32])) r[k] = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    if (!a[0]) en_m[a[1]*32 +: 32] = d & WIRED[a[1]*32 +: 32];
  endtask

  task automatic rd(string tag, logic [1:0] a, logic [31:0] exp);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 chk(tag, 64'(rdata), 64'(exp));
    req = 1'b0;
  endtask

  task automatic set_src(logic [63:0] s);
    @(negedge clk);
    src = s;
    @(negedge clk);
  endtask

  task automatic chk_out(string tag);
    chk({tag, " parent"}, 64'(par), 64'(exp_par(src, en_m)));
    chk({tag, " wake"}, 64'(wake), 64'(|live_f(src, en_m)));
    chk({tag, " bypass"}, byp, src & WIRED & FWD);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (2) @(posedge clk);
    @(negedge clk);
    addr = 2'd0; #1 chk("R1 en0 in reset", 64'(rdata), 64'h0);
    addr = 2'd2; #1 chk("R1 en1 in reset", 64'(rdata), 64'h0);
    chk("R1 parent in reset", 64'(par), 64'h0);
    chk("R1 wake in reset", 64'(wake), 64'h0);
    rst_ni = 1'b1;
    rd("R1 en0 after reset", 2'd0, 32'h0);
    rd("R1 en1 after reset", 2'd2, 32'h0);

    wr(2'd0, 32'hFFFF_FFFF);
    rd("R2 en0 readback masked", 2'd0, 32'hFFFF_7FFE);
    wr(2'd2, 32'hFFFF_FFFF);
    rd("R4 en1 at offset 0x8", 2'd2, 32'h0FFF_00FF);

    set_src(64'hA5A5_5A5A_DEAD_BEEF);
    rd("R3 status0 live", 2'd1, 32'hDEAD_BEEF & 32'hFFFF_7FFE);
    rd("R4 status1 at 0xC", 2'd3, 32'hA5A5_5A5A & 32'h0FFF_00FF);
    wr(2'd1, 32'h0);
    wr(2'd3, 32'h0);
    rd("R3 status write ignored en0", 2'd0, 32'hFFFF_7FFE);
    rd("R3 status write ignored en1", 2'd2, 32'h0FFF_00FF);

    set_src(64'h1);
    chk("R10 unwired source parent", 64'(par), 64'h0);
    chk("R10 unwired source wake", 64'(wake), 64'h0);

    @(negedge clk); src = 64'h8;
    #1 chk("R5 parent not yet updated", 64'(par), 64'h0);
    @(negedge clk);
    chk("R5 parent0 from bit 3", 64'(par), 64'h1);

    set_src(64'(1) << 52);
    chk("R6 bit 52 to parent2", 64'(par), 64'h4);
    set_src(64'(1) << 34);
    chk("R6 bit 34 to parent1", 64'(par), 64'h2);

    set_src(64'h2);
    chk("R7 bypass bit 1", byp, 64'h2);
    chk("R7 forwarded bit 1 parent", 64'(par), 64'h0);
    chk("R7 forwarded bit 1 wake", 64'(wake), 64'h0);
    set_src(64'(1) << 33);
    chk("R7 bypass bit 33", byp, 64'(1) << 33);
    chk("R7 forwarded bit 33 parent", 64'(par), 64'h0);

    set_src(64'h400);
    chk("R8 unmapped bit 10 parent", 64'(par), 64'h0);
    chk("R8 unmapped bit 10 wake", 64'(wake), 64'h1);

    set_src(64'h8);
    chk("R9 setup parent0", 64'(par), 64'h1);
    wr(2'd0, 32'h0);
    chk("R9 parent holds one more edge", 64'(par), 64'h1);
    @(negedge clk);
    chk("R9 parent drops after disable", 64'(par), 64'h0);
    wr(2'd0, 32'h8);
    @(negedge clk);
    chk("R9 parent rises after enable", 64'(par), 64'h1);

    for (int i = 0; i < 300; i++) begin
      if (($urandom % 4) == 0) wr(2'(($urandom % 2) * 2), $urandom);
      set_src({$urandom, $urandom} & {$urandom, $urandom});
      chk_out("R5 R7 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule